// File: doc/BRIEF.md
# Password-Guarded GPIO Bank

This block is a bank of general-purpose pins with a word-wide register bus (address, write data, write enable, combinational read data). Every pin has its own control word whose bit 0 picks its direction. The driven levels live in one output-state word that software changes only through two write-one-to-act strobes: one raises pins and one lowers them. An input synchronizer samples the pads. A combined read view returns, for each pin, the synchronized pad level if the pin is an input or the driven level if it is an output.

Each pin also has a protect bit. While a pin is protected, writes to its control word and set or clear requests for it are dropped. The protect word itself can only be rewritten through a two-write handshake. First the magic value 0x00A5A501 goes to the key register. Then the very next bus write must target the protect word. A small two-state machine tracks the handshake. In state KEY_IDLE, a correct key write takes transition T_ARM to state KEY_ARMED. In KEY_ARMED, a protect-word write loads the word and takes T_COMMIT back to KEY_IDLE. Another correct key write takes T_REARM and stays in KEY_ARMED. Any other write takes T_ABORT to KEY_IDLE and changes nothing in the protect word. From reset every pin is an input, every output is low and every pin is protected.

Top module: `glk_gpio_bank`

Byte addresses (word aligned): 0x000 output state (read), 0x004 input state (read), 0x008 set strobe (write), 0x00C clear strobe (write), 0x010 combined pin view (read), 0x020 key (write, reads 0), 0x024 protect word (read/write), 0x100 + 4*n control word of pin n. Any other address reads 0.

## Requirements
- R1: After reset the protect word reads 0xFFFFFFFF, the output state reads 0, every control word reads 1 and pin_oe is all zeros.
- R2: A write of 0x00A5A501 to the key register at 0x020, followed directly by a write to 0x024, loads the protect word from the write data (bit n = 1 protects pin n, 0 unprotects it).
- R3: A write to 0x024 that does not directly follow a correct key write leaves the protect word unchanged.
- R4: Any write other than a correct key write or a protect-word write, made between the key write and the protect-word write, cancels the handshake. This includes a key write with a wrong value.
- R5: The control word of pin n sits at 0x100 + 4*n. Bit 0 set to 1 makes the pin an input and 0 makes it an output, and pin_oe[n] is the inverse of that bit. A write to the control word of a protected pin is ignored. Addresses past the last pin read 0.
- R6: Writing to 0x008 sets to 1 each output bit whose write-data bit is 1. Zero bits change nothing. pin_out follows the output state.
- R7: Writing to 0x00C clears to 0 each output bit whose write-data bit is 1. Zero bits change nothing.
- R8: Set and clear requests for a protected pin leave that pin's output bit unchanged.
- R9: Set and clear requests for a pin configured as an input leave its output bit unchanged.
- R10: 0x004 returns pin_in as seen through a SYNC_STAGES-deep synchronizer.
- R11: 0x010 returns, per pin, the synchronized input when bit 0 of its control word is 1 and the output-state bit when it is 0. 0x000 returns the output state.
- R12: A new protect word takes effect on the first write after the one that loaded it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NPINS (32) | Pad input levels |
| pin_out | output | NPINS (32) | Driven output levels |
| pin_oe | output | NPINS (32) | Output enables, 1 = drive |

## Verification
The bench builds the block with its defaults: NPINS = 32, SYNC_STAGES = 2 and ADDR_W = 12. With 32 pins, the last control word at 0x17C and the first unmapped word at 0x180 both lie within the tested address range. The full-width protect word also lets all-ones and mixed patterns show the protect and direction rules interacting on the same pins. The two-stage synchronizer keeps the input-latency check short enough to probe right after a pad change.

// File: rtl/glk_pkg.sv
package glk_pkg;

    typedef enum logic [0:0] {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

    localparam int OFS_OUT_STATE = 'h000;
    localparam int OFS_IN_STATE  = 'h004;
    localparam int OFS_SET       = 'h008;
    localparam int OFS_CLR       = 'h00C;
    localparam int OFS_PIN_VIEW  = 'h010;
    localparam int OFS_KEY       = 'h020;
    localparam int OFS_PROTECT   = 'h024;
    localparam int OFS_CTRL_BASE = 'h100;

    localparam logic [31:0] KEY_MAGIC = 32'h00A5_A501;

endpackage

// File: rtl/glk_key_fsm.sv
module glk_key_fsm
    import glk_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              key_sel,
    input  logic              prot_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [NPINS-1:0]  prot_q
);

    key_state_e state_q, state_d;
    logic       key_ok;
    logic       commit;

    assign key_ok = wr_en && key_sel && (wdata == KEY_MAGIC);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    // next state: T_ARM, T_REARM, T_COMMIT, T_ABORT
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            KEY_IDLE: begin
                if (key_ok) state_d = KEY_ARMED;
            end
            KEY_ARMED: begin
                if (wr_en) begin
                    if (key_ok) begin
                        state_d = KEY_ARMED;
                    end else begin
                        state_d = KEY_IDLE;
                        commit  = prot_sel;
                    end
                end
            end
            default: state_d = KEY_IDLE;
        endcase
    end

    // outputs: protect word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      prot_q <= '1;
        else if (commit) prot_q <= wdata[NPINS-1:0];
    end

    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KEY_IDLE) |=> $stable(prot_q));

    a_r4_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KEY_ARMED && wr_en && !key_sel && !prot_sel) |=>
            (state_q == KEY_IDLE && $stable(prot_q)));

    a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KEY_IDLE && wr_en && key_sel && wdata == KEY_MAGIC) |=>
            (state_q == KEY_ARMED));

endmodule

// File: rtl/glk_pin_cfg.sv
module glk_pin_cfg #(
    parameter int NPINS = 32,
    parameter int IDX_W = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             ctrl_sel,
    input  logic [IDX_W-1:0] ctrl_idx,
    input  logic             wbit,
    input  logic [NPINS-1:0] prot,
    output logic [NPINS-1:0] dir_q
);

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        logic hit;
        assign hit = wr_en && ctrl_sel && (ctrl_idx == IDX_W'(n)) && !prot[n];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   dir_q[n] <= 1'b1;
            else if (hit) dir_q[n] <= wbit;
        end

        a_r5_protected_dir: assert property (@(posedge clk) disable iff (!rst_n)
            prot[n] |=> $stable(dir_q[n]));
    end

endmodule

// File: rtl/glk_out_bank.sv
module glk_out_bank #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic             clr_stb,
    input  logic [NPINS-1:0] wmask,
    input  logic [NPINS-1:0] prot,
    input  logic [NPINS-1:0] dir,
    output logic [NPINS-1:0] out_q
);

    for (genvar i = 0; i < NPINS; i++) begin : g_bit
        logic open_bit;
        assign open_bit = wmask[i] && !prot[i] && !dir[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    out_q[i] <= 1'b0;
            else if (set_stb && open_bit)  out_q[i] <= 1'b1;
            else if (clr_stb && open_bit)  out_q[i] <= 1'b0;
        end

        a_r8_r9_guarded: assert property (@(posedge clk) disable iff (!rst_n)
            (prot[i] || dir[i]) |=> $stable(out_q[i]));

        a_r6_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (set_stb && wmask[i] && !prot[i] && !dir[i]) |=> out_q[i]);

        a_r7_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_stb && wmask[i] && !prot[i] && !dir[i]) |=> !out_q[i]);
    end

    a_r6_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_stb && clr_stb));

endmodule

// File: rtl/glk_in_sync.sv
module glk_in_sync #(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] in_q
);

    logic [NPINS-1:0] stage_q [SYNC_STAGES];

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= pin_in;
            else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign in_q = stage_q[SYNC_STAGES-1];

endmodule

// File: rtl/glk_gpio_bank.sv
module glk_gpio_bank
    import glk_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe
);

    localparam int IDX_W    = (NPINS > 1) ? $clog2(NPINS) : 1;
    localparam int CTRL_END = OFS_CTRL_BASE + 4 * NPINS;

    logic [NPINS-1:0]  prot_q, dir_q, out_q, in_q;
    logic [ADDR_W-1:0] ctrl_off;
    logic [IDX_W-1:0]  ctrl_idx;
    logic              ctrl_sel, key_sel, prot_sel, set_sel, clr_sel;

    assign key_sel  = (bus_addr == ADDR_W'(OFS_KEY));
    assign prot_sel = (bus_addr == ADDR_W'(OFS_PROTECT));
    assign set_sel  = (bus_addr == ADDR_W'(OFS_SET));
    assign clr_sel  = (bus_addr == ADDR_W'(OFS_CLR));
    assign ctrl_off = bus_addr - ADDR_W'(OFS_CTRL_BASE);
    assign ctrl_idx = ctrl_off[IDX_W+1:2];
    assign ctrl_sel = (bus_addr >= ADDR_W'(OFS_CTRL_BASE)) &&
                      (bus_addr <  ADDR_W'(CTRL_END)) &&
                      (bus_addr[1:0] == 2'b00);

    glk_key_fsm #(.NPINS(NPINS), .DATA_W(32)) u_key (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .key_sel(key_sel),
        .prot_sel(prot_sel), .wdata(bus_wdata), .prot_q(prot_q)
    );

    glk_pin_cfg #(.NPINS(NPINS), .IDX_W(IDX_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .ctrl_sel(ctrl_sel),
        .ctrl_idx(ctrl_idx), .wbit(bus_wdata[0]), .prot(prot_q), .dir_q(dir_q)
    );

    glk_out_bank #(.NPINS(NPINS)) u_out (
        .clk(clk), .rst_n(rst_n), .set_stb(bus_we && set_sel),
        .clr_stb(bus_we && clr_sel), .wmask(bus_wdata[NPINS-1:0]),
        .prot(prot_q), .dir(dir_q), .out_q(out_q)
    );

    glk_in_sync #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .in_q(in_q)
    );

    assign pin_out = out_q;
    assign pin_oe  = ~dir_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_OUT_STATE))     bus_rdata[NPINS-1:0] = out_q;
        else if (bus_addr == ADDR_W'(OFS_IN_STATE)) bus_rdata[NPINS-1:0] = in_q;
        else if (bus_addr == ADDR_W'(OFS_PIN_VIEW))
            bus_rdata[NPINS-1:0] = (dir_q & in_q) | (~dir_q & out_q);
        else if (prot_sel)                          bus_rdata[NPINS-1:0] = prot_q;
        else if (ctrl_sel)                          bus_rdata[0] = dir_q[ctrl_idx];
    end

    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (prot_q == '1 && out_q == '0 && pin_oe == '0));

    a_r5_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && ctrl_sel && !prot_q[ctrl_idx]) |=>
            (pin_oe[$past(ctrl_idx)] == !$past(bus_wdata[0])));

endmodule

// File: tb/sim_glk_gpio_bank.sv
`timescale 1ns/1ps
module sim_glk_gpio_bank;

    localparam int NPINS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;

    always #2.5 clk = ~clk;

    glk_gpio_bank #(.NPINS(NPINS), .SYNC_STAGES(2), .ADDR_W(12)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    typedef struct {
        int          kind;   // 0 read data, 1 pin_out, 2 pin_oe
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    // monitor: compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? pin_out : pin_oe;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%08h expected=%08h",
                             it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_addr = a;
        it.kind = 0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic pins(input int kind, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_we = 1'b0;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic unlock_load(input logic [31:0] word);
        wr(12'h020, 32'h00A5_A501);
        wr(12'h024, word);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(12'h024, 32'hFFFF_FFFF, "R1 protect word");
        rd(12'h000, 32'h0, "R1 output state");
        rd(12'h100, 32'h1, "R1 control pin0");
        pins(2, 32'h0, "R1 pin_oe");

        // R3 protect write without key
        wr(12'h024, 32'h0);
        rd(12'h024, 32'hFFFF_FFFF, "R3 no key");

        // R2 handshake
        unlock_load(32'hFFFF_FF00);
        rd(12'h024, 32'hFFFF_FF00, "R2 protect loaded");

        // R5 direction, protected pin 8 ignored
        wr(12'h100, 32'h0);
        wr(12'h104, 32'h0);
        wr(12'h120, 32'h0);
        rd(12'h100, 32'h0, "R5 pin0 output");
        rd(12'h120, 32'h1, "R5 protected pin8");
        pins(2, 32'h0000_0003, "R5 pin_oe");

        // R6 set, R8/R9 filtering
        wr(12'h008, 32'hFFFF_FF05);
        rd(12'h000, 32'h1, "R6 set masked");
        pins(1, 32'h1, "R6 pin_out");
        wr(12'h008, 32'h2);
        rd(12'h000, 32'h3, "R6 second set");
        // R7 clear
        wr(12'h00C, 32'h1);
        rd(12'h000, 32'h2, "R7 clear");
        wr(12'h00C, 32'h0);
        rd(12'h000, 32'h2, "R7 zero clear");
        // R9 input pin 2 unaffected
        wr(12'h008, 32'h4);
        rd(12'h000, 32'h2, "R9 input pin set");

        // R4 intervening write aborts
        wr(12'h020, 32'h00A5_A501);
        wr(12'h008, 32'h1);
        wr(12'h024, 32'h0);
        rd(12'h024, 32'hFFFF_FF00, "R4 abort by set write");
        rd(12'h000, 32'h3, "R4 set write applied");
        wr(12'h020, 32'h00A5_A500);
        wr(12'h024, 32'h0);
        rd(12'h024, 32'hFFFF_FF00, "R4 wrong key");

        // R8 protect pin0, clear both
        unlock_load(32'hFFFF_FF01);
        wr(12'h00C, 32'h3);
        rd(12'h000, 32'h1, "R8 protected pin kept");
        wr(12'h100, 32'h1);
        rd(12'h100, 32'h0, "R8 protected control");

        // R10 input sync
        pin_in = 32'hA5A5_0F0F;
        repeat (3) @(posedge clk);
        rd(12'h004, 32'hA5A5_0F0F, "R10 input state");

        // R11 combined view
        rd(12'h010, 32'hA5A5_0F0D, "R11 pin view");
        rd(12'h000, 32'h1, "R11 output state");

        // R5 boundary
        rd(12'h17C, 32'h1, "R5 last pin control");
        rd(12'h180, 32'h0, "R5 past last pin");
        unlock_load(32'h7FFF_FF01);
        wr(12'h17C, 32'h0);
        pins(2, 32'h8000_0003, "R5 pin31 output");

        // R12 protect all, next write blocked
        unlock_load(32'hFFFF_FFFF);
        wr(12'h008, 32'h2);
        rd(12'h000, 32'h1, "R12 new protect effective");

        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule